// File: doc/BRIEF.md
# Converter Result Readback Port

This block is the serial output side of a delta-sigma converter, acting as an SPI target in mode 1. Each 24-bit conversion result arrives with a one-cycle ready strobe in the modulator clock domain. The block holds the result in a buffer and drives the active-low data-ready pin low. When the host starts a frame, the block takes a snapshot of the buffer and shifts it out on SDO. The frame can carry an optional 16-bit status header before the data and an optional CRC byte after it. Because each frame shifts its own snapshot, a result that arrives in the middle of a frame never tears the bits on the wire.

The serial pins are synchronised into the modulator clock and their edges are found there, so the whole block runs on one clock. A host reads with a two-byte command word. With CRC enabled, a CRC byte follows the command; a no-operation frame sends 00h 00h D7h. The block checks that CRC at the end of every frame and reports the result on an active-low fault flag. When the command decoder flags a register-read command during a frame, the next frame carries the supplied register data in place of the conversion result.

Top module: `adc_readout_port`

## Requirements
- R1: After reset, `drdy_n` and `crc_fault_n` are high. `spi_sdo_oe` is high exactly while `spi_cs_n` is low.
- R2: A frame is sent MSB first, and SDO changes after SCLK rising edges. The bit order is the 16-bit header (only when `cfg_status_en`=1), then the 24-bit data, then the CRC byte (only when `cfg_crc_en`=1).
- R3: `drdy_n` goes low on the clock after `res_valid`, and the result is latched into the buffer on that same clock.
- R4: With the header disabled, `drdy_n` returns high at the 8th SCLK falling edge of a frame that carries an unread result.
- R5: With the header enabled, `drdy_n` returns high at the 24th SCLK falling edge of such a frame.
- R6: A frame aborted (CS raised) after the release edge still leaves `drdy_n` high. A frame aborted before that edge leaves `drdy_n` low.
- R7: A result can be read any number of times and stays the same. A result that arrives during a frame does not change that frame's data, and `drdy_n` stays low for the new result.
- R8: Header bit 15 is 1 when the frame carries an unread result and 0 when it repeats one. Header bit 14 is the value of `crc_fault_n` at frame start. Bits 13..0 are 0.
- R9: The output CRC is CRC-8 with polynomial 07h and initial value FFh, computed MSB first. It covers the header and the data when the header is enabled, and the data alone when it is not.
- R10: With `cfg_crc_en`=1, at each CS rising edge `crc_fault_n` becomes 1 only if the frame had at least 24 falling edges and its third input byte equals the CRC of the first two (00h 00h gives D7h). Otherwise it becomes 0. With `cfg_crc_en`=0 it becomes 1.
- R11: If `reg_rd_req` is high during a frame, the next frame sends `reg_rd_data` in the data field. That frame has header bit 15 = 0 and does not change `drdy_n`. The frame after it sends conversion data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_status_en | input | 1 | Put the 16-bit status header in front of the data |
| cfg_crc_en | input | 1 | Append the output CRC and check the input CRC |
| res_valid | input | 1 | One-cycle strobe: new conversion result |
| res_data | input | 24 | Conversion result |
| reg_rd_req | input | 1 | Command decoder saw a register-read command in this frame |
| reg_rd_data | input | 24 | Register data for the next frame |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_sdi | input | 1 | SPI data in, sampled on SCLK falling edges |
| spi_sdo | output | 1 | SPI data out |
| spi_sdo_oe | output | 1 | Output enable for SDO (high-impedance when low) |
| drdy_n | output | 1 | Data ready, active low |
| crc_fault_n | output | 1 | Input CRC fault flag, active low |

## Verification
The hardest case to reach from the ports is a result strobe that lands after a frame has taken its snapshot but before the release edge. A correct design must send the old value in that frame, must not release `drdy_n`, and must hand the new value to the following frame. The bench reaches this by forking the frame task and a delayed result push, so the strobe falls a few SCLK bits into the frame. Aborted frames on each side of the release edge and a deliberately wrong input CRC byte cover the other two corner cases.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   localparam logic [7:0] CRC8_POLY = 8'h07;
   localparam logic [7:0] CRC8_INIT = 8'hFF;
   localparam int unsigned CRC8_W   = 8;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
   parameter int unsigned    W       = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= RST_VAL;
            else        stg_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {STAGES{RST_VAL}};
            else        stg_q <= {stg_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/adc_rd_crc8.sv
module adc_rd_crc8 #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] din,
   output logic [7:0]   crc
);
   import adc_rd_pkg::*;

   always_comb begin
      logic [7:0] c;
      logic       fb;
      c = CRC8_INIT;
      for (int i = N - 1; i >= 0; i--) begin
         fb = c[7] ^ din[i];
         c  = {c[6:0], 1'b0} ^ (fb ? CRC8_POLY : 8'h00);
      end
      crc = c;
   end
endmodule

// File: rtl/adc_readout_port.sv
module adc_readout_port #(
   parameter int unsigned DATA_W      = 24,
   parameter int unsigned STAT_W      = 16,
   parameter int unsigned CMD_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_status_en,
   input  logic              cfg_crc_en,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              reg_rd_req,
   input  logic [DATA_W-1:0] reg_rd_data,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   output logic              drdy_n,
   output logic              crc_fault_n
);
   import adc_rd_pkg::*;

   localparam int unsigned FW   = STAT_W + DATA_W + CRC8_W;
   localparam int unsigned RX_W = CMD_W + CRC8_W;
   localparam int unsigned CW   = $clog2(FW + 1);
   localparam logic [CW-1:0] END_PLAIN = CW'(8);
   localparam logic [CW-1:0] END_HDR   = CW'(STAT_W + 8);
   localparam logic [CW-1:0] RX_END    = CW'(RX_W);
   localparam logic [CW-1:0] CNT_MAX   = CW'(FW);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (CMD_W % 8 != 0 || CMD_W < 8) begin : g_bad_cmd_w
         $error("CMD_W must be a non-zero multiple of 8");
      end
      if (STAT_W < 2) begin : g_bad_stat_w
         $error("STAT_W must hold the fresh and fault bits");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   // pin synchronisation and edge detection
   logic [2:0] s_vec;
   logic       s_cs_n, s_sclk, s_sdi;
   logic       prev_cs_n, prev_sclk;

   adc_rd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_sdi}),
      .q     (s_vec)
   );
   assign {s_cs_n, s_sclk, s_sdi} = s_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs_n <= 1'b1;
         prev_sclk <= 1'b0;
      end else begin
         prev_cs_n <= s_cs_n;
         prev_sclk <= s_sclk;
      end
   end

   logic frame_start, frame_end, sclk_rise, sclk_fall;
   assign frame_start = prev_cs_n & ~s_cs_n;
   assign frame_end   = ~prev_cs_n & s_cs_n;
   assign sclk_rise   = ~s_cs_n & ~prev_sclk & s_sclk;
   assign sclk_fall   = ~s_cs_n & prev_sclk & ~s_sclk;

   // result buffer and ready tracking
   logic [DATA_W-1:0] hold_q;
   logic              fresh_q, drdy_q, snap_new_q;
   logic [CW-1:0]     fall_cnt_q, fall_cnt_nx;
   logic [CW-1:0]     msb_end;
   logic              release_now;

   assign fall_cnt_nx = (fall_cnt_q == CNT_MAX) ? fall_cnt_q : fall_cnt_q + CW'(1);
   assign msb_end     = cfg_status_en ? END_HDR : END_PLAIN;
   assign release_now = sclk_fall & snap_new_q & (fall_cnt_nx == msb_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         fresh_q <= 1'b0;
         drdy_q  <= 1'b1;
      end else if (res_valid) begin
         hold_q  <= res_data;
         fresh_q <= 1'b1;
         drdy_q  <= 1'b0;
      end else if (release_now) begin
         fresh_q <= 1'b0;
         drdy_q  <= 1'b1;
      end
   end

   // register-read substitution
   logic reg_seen_q, reg_pend_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_seen_q <= 1'b0;
         reg_pend_q <= 1'b0;
      end else begin
         if (frame_end) begin
            reg_pend_q <= reg_seen_q | reg_rd_req;
            reg_seen_q <= 1'b0;
         end else begin
            if (frame_start) reg_pend_q <= 1'b0;
            if (reg_rd_req && !s_cs_n) reg_seen_q <= 1'b1;
         end
      end
   end

   // frame assembly
   logic [DATA_W-1:0] pay_nx;
   logic [STAT_W-1:0] hdr_nx;
   logic              new_nx;
   logic [7:0]        crc_hd, crc_d, crc_out;
   logic [FW-1:0]     tx_nx, tx_q;
   logic              crc_fault_q;

   assign pay_nx = reg_pend_q ? reg_rd_data : hold_q;
   assign new_nx = ~reg_pend_q & fresh_q;
   assign hdr_nx = {new_nx, crc_fault_q, {(STAT_W-2){1'b0}}};

   adc_rd_crc8 #(.N(STAT_W + DATA_W)) u_crc_hd (.din({hdr_nx, pay_nx}), .crc(crc_hd));
   adc_rd_crc8 #(.N(DATA_W))          u_crc_d  (.din(pay_nx),           .crc(crc_d));

   always_comb begin
      crc_out = cfg_crc_en ? (cfg_status_en ? crc_hd : crc_d) : 8'h00;
      if (cfg_status_en) tx_nx = {hdr_nx, pay_nx, crc_out};
      else               tx_nx = {pay_nx, crc_out, {STAT_W{1'b0}}};
   end

   logic sdo_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q       <= '0;
         sdo_q      <= 1'b0;
         snap_new_q <= 1'b0;
         fall_cnt_q <= '0;
      end else begin
         if (frame_start) begin
            tx_q       <= tx_nx;
            fall_cnt_q <= '0;
         end else begin
            if (sclk_rise) begin
               sdo_q <= tx_q[FW-1];
               tx_q  <= {tx_q[FW-2:0], 1'b0};
            end
            if (sclk_fall) fall_cnt_q <= fall_cnt_nx;
         end
         if (res_valid || release_now) snap_new_q <= 1'b0;
         else if (frame_start)         snap_new_q <= new_nx;
      end
   end

   // command capture and input CRC check
   logic [RX_W-1:0] rx_q;
   logic [7:0]      crc_rx;
   logic            rx_ok;

   adc_rd_crc8 #(.N(CMD_W)) u_crc_rx (.din(rx_q[RX_W-1:CRC8_W]), .crc(crc_rx));
   assign rx_ok = (fall_cnt_q >= RX_END) && (crc_rx == rx_q[CRC8_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q        <= '0;
         crc_fault_q <= 1'b1;
      end else begin
         if (frame_start) rx_q <= '0;
         else if (sclk_fall && fall_cnt_q < RX_END) rx_q <= {rx_q[RX_W-2:0], s_sdi};
         if (frame_end) crc_fault_q <= cfg_crc_en ? rx_ok : 1'b1;
      end
   end

   assign spi_sdo     = sdo_q;
   assign spi_sdo_oe  = ~spi_cs_n;
   assign drdy_n      = drdy_q;
   assign crc_fault_n = crc_fault_q;

   // R3
   drdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_q) |-> $past(res_valid));
   // R4
   drdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drdy_q) |-> $past(sclk_fall && !s_cs_n));
   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_q) |-> $past(res_valid));
   // R2
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo_q) |-> $past(sclk_rise));
   // R10
   fault_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_fault_q) |-> $past(frame_end));
endmodule

// File: tb/tb_adc_readout_port.sv
module tb_adc_readout_port;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_status_en = 1'b0, cfg_crc_en = 1'b0;
   logic        res_valid = 1'b0;
   logic [23:0] res_data = '0;
   logic        reg_rd_req = 1'b0;
   logic [23:0] reg_rd_data = '0;
   logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
   logic        spi_sdo, spi_sdo_oe, drdy_n, crc_fault_n;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   adc_readout_port dut (
      .clk(clk), .rst_n(rst_n), .cfg_status_en(cfg_status_en), .cfg_crc_en(cfg_crc_en),
      .res_valid(res_valid), .res_data(res_data), .reg_rd_req(reg_rd_req),
      .reg_rd_data(reg_rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
      .drdy_n(drdy_n), .crc_fault_n(crc_fault_n)
   );

   function automatic logic [7:0] crc8(input logic [47:0] d, input int n);
      logic [7:0] c = 8'hFF;
      logic fb;
      for (int i = n - 1; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   function automatic logic [15:0] hdr(input logic fresh, input logic flag);
      return {fresh, flag, 14'b0};
   endfunction

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [23:0] v);
      @(negedge clk);
      res_data  = v;
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      chk("R3 drdy low after result", 48'(drdy_n), 48'(0));
   endtask

   task automatic xfer(input int n, input logic [23:0] cmd, output logic [47:0] rx, output int rel);
      logic d0;
      rx  = '0;
      rel = 0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      d0 = drdy_n;
      for (int i = 0; i < n; i++) begin
         spi_sclk = 1'b1;
         spi_sdi  = (i < 24) ? cmd[23 - i] : 1'b0;
         repeat (HALF) @(negedge clk);
         rx = {rx[46:0], spi_sdo};
         spi_sclk = 1'b0;
         repeat (HALF) @(negedge clk);
         if (!d0 && drdy_n && rel == 0) rel = i + 1;
      end
      spi_cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 drdy_n reset", 48'(drdy_n), 48'(1));
      chk("R1 crc_fault_n reset", 48'(crc_fault_n), 48'(1));
      chk("R1 sdo_oe idle", 48'(spi_sdo_oe), 48'(0));
      @(negedge clk) spi_cs_n = 1'b0;
      @(negedge clk);
      chk("R1 sdo_oe selected", 48'(spi_sdo_oe), 48'(1));
      spi_cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic t_plain;
      logic [47:0] rx; int rel;
      cfg_status_en = 1'b0; cfg_crc_en = 1'b0;
      push(24'h5A3C81);
      xfer(24, 24'h0, rx, rel);
      chk("R2 plain data", rx & 48'hFFFFFF, 48'h5A3C81);
      chk("R4 release at 8th fall", 48'(rel), 48'(8));
      xfer(24, 24'h0, rx, rel);
      chk("R7 repeat read", rx & 48'hFFFFFF, 48'h5A3C81);
      chk("R7 drdy stays high", 48'(drdy_n), 48'(1));
   endtask

   task automatic t_hdr;
      logic [47:0] rx; int rel; logic [39:0] body;
      cfg_status_en = 1'b1; cfg_crc_en = 1'b1;
      push(24'hC3E017);
      body = {hdr(1'b1, 1'b1), 24'hC3E017};
      xfer(48, 24'h0000D7, rx, rel);
      chk("R9 header+data+crc", rx, {body, crc8(48'(body), 40)});
      chk("R5 release at 24th fall", 48'(rel), 48'(24));
      chk("R10 good crc keeps flag", 48'(crc_fault_n), 48'(1));
      xfer(48, 24'h0000D7, rx, rel);
      chk("R8 repeat header", rx[47:32], 48'(hdr(1'b0, 1'b1)));
   endtask

   task automatic t_crc_in;
      logic [47:0] rx; int rel;
      cfg_status_en = 1'b1; cfg_crc_en = 1'b1;
      xfer(48, 24'h000000, rx, rel);
      chk("R10 wrong crc byte", 48'(crc_fault_n), 48'(0));
      xfer(48, 24'h0000D7, rx, rel);
      chk("R8 fault bit in header", rx[47:32], 48'(hdr(1'b0, 1'b0)));
      chk("R10 flag re-evaluated", 48'(crc_fault_n), 48'(1));
      xfer(16, 24'h0000D7, rx, rel);
      chk("R10 short frame", 48'(crc_fault_n), 48'(0));
      cfg_status_en = 1'b0;
      push(24'h1E2D3C);
      xfer(32, 24'h0000D7, rx, rel);
      chk("R9 data-only crc", rx & 48'hFFFFFFFF, 48'({24'h1E2D3C, crc8(48'h1E2D3C, 24)}));
      xfer(16, 24'h0, rx, rel);
      cfg_crc_en = 1'b0;
      xfer(24, 24'h0, rx, rel);
      chk("R10 crc disabled", 48'(crc_fault_n), 48'(1));
   endtask

   task automatic t_abort;
      logic [47:0] rx; int rel;
      cfg_status_en = 1'b1; cfg_crc_en = 1'b0;
      push(24'h777000);
      xfer(20, 24'h0, rx, rel);
      chk("R6 abort before msb end", 48'(drdy_n), 48'(0));
      xfer(30, 24'h0, rx, rel);
      chk("R6 abort after msb end", 48'(drdy_n), 48'(1));
      chk("R6 release edge", 48'(rel), 48'(24));
   endtask

   task automatic t_midframe;
      logic [47:0] rx; int rel;
      cfg_status_en = 1'b0; cfg_crc_en = 1'b0;
      push(24'hABCDEF);
      fork
         xfer(24, 24'h0, rx, rel);
         begin
            repeat (40) @(negedge clk);
            push(24'h123456);
         end
      join
      chk("R7 no torn data", rx & 48'hFFFFFF, 48'hABCDEF);
      chk("R7 drdy held for new result", 48'(drdy_n), 48'(0));
      xfer(24, 24'h0, rx, rel);
      chk("R7 next frame new data", rx & 48'hFFFFFF, 48'h123456);
      chk("R4 release on next frame", 48'(rel), 48'(8));
   endtask

   task automatic t_regread;
      logic [47:0] rx; int rel;
      cfg_status_en = 1'b1; cfg_crc_en = 1'b0;
      reg_rd_data = 24'h00BEEF;
      push(24'h424242);
      reg_rd_req = 1'b1;
      xfer(40, 24'h0, rx, rel);
      reg_rd_req = 1'b0;
      chk("R11 request frame data", rx & 48'hFFFFFFFFFF, {8'h0, hdr(1'b1, 1'b1), 24'h424242});
      push(24'h999999);
      xfer(40, 24'h0, rx, rel);
      chk("R11 register data frame", rx & 48'hFFFFFFFFFF, {8'h0, hdr(1'b0, 1'b1), 24'h00BEEF});
      chk("R11 drdy untouched", 48'(drdy_n), 48'(0));
      xfer(40, 24'h0, rx, rel);
      chk("R11 back to conversion", rx & 48'hFFFFFFFFFF, {8'h0, hdr(1'b1, 1'b1), 24'h999999});
      chk("R5 release after reg frame", 48'(drdy_n), 48'(1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_plain();
      t_hdr();
      t_crc_in();
      t_abort();
      t_midframe();
      t_regread();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule